// File: doc/BRIEF.md
# Floating-Point Compare Unit with Condition Flags

This block orders two IEEE-754 operands and reports the outcome as four condition flags: negative (N), zero (Z), carry (C) and overflow (V). One input picks between the narrow (single) and the wide (double) format. A second input swaps the right-hand operand for positive zero, so a value can be tested against zero without being loaded. The flags stay in a status register until the next compare or reset.

Compare requests come in on a valid/ready stream. `cmp_ready` is tied high, so the unit never applies back-pressure. Every cycle with `cmp_valid` high is one compare, and its operands are taken in that same cycle. The flags are always visible on a 32-bit status word. A separate one-cycle transfer strobe copies them into a core condition-flag register.

Top module: `fcmp_nzcv`

## Requirements
- R1: While `rst_n` is low, and after it rises, the flag register, `status_word` and `core_flags` are all zero until the first compare or transfer.
- R2: When either operand is a NaN (exponent all ones, mantissa non-zero), the flags become C and V set with N and Z clear (NZCV = 0011).
- R3: When the operands are numerically equal, the flags become Z and C set (NZCV = 0110).
- R4: When the left operand is less than the right one, only N is set (1000). When it is greater, only C is set (0010).
- R5: +0.0 and -0.0 compare equal. Infinities order by sign: +inf is above every finite value, -inf is below every finite value, and same-signed infinities are equal.
- R6: With `dbl_sel` = 0, only the low SW bits of each operand are used, as the single format, and the upper operand bits are ignored. With `dbl_sel` = 1, the full DW bits are used as the double format.
- R7: With `cmp_zero` = 1, the right operand is replaced by +0.0 (all zero bits) of the selected format, and `op_b` is ignored.
- R8: The flags load on the rising edge where `cmp_valid` && `cmp_ready` is true. On every other edge they hold their value.
- R9: `status_word` carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. All other bits are zero.
- R10: On a rising edge with `xfer_core` high, `core_flags` ({N,Z,C,V} in bits 3..0) takes the value the flag register held before that edge, so a compare in the same cycle is not included. On other edges `core_flags` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request valid |
| cmp_ready | output | 1 | Compare request ready (always 1) |
| dbl_sel | input | 1 | 1 = double format, 0 = single format |
| cmp_zero | input | 1 | 1 = compare left operand against +0.0 |
| op_a | input | DW | Left operand |
| op_b | input | DW | Right operand |
| xfer_core | input | 1 | Copy flags into the core flag register |
| status_word | output | STAT_W | Packed flags in bits 31..28 |
| core_flags | output | 4 | Core condition flags {N,Z,C,V} |

## Verification
The bench builds the unit with two tiny formats: a 6-bit single (3 exponent bits, 2 mantissa bits) and a 7-bit double (3 exponent bits, 3 mantissa bits). At these widths every operand pair of both formats can be swept, which covers every NaN, infinity, subnormal and signed-zero combination. During the single-format sweep the unused top operand bit is set to junk. A behavioural model turns each encoding into a real number to produce the expected flags. Directed sequences then cover holding, the transfer strobe and a mid-run reset.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } order_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic nzcv_t flags_of(order_e o);
    nzcv_t f;
    f = '0;
    case (o)
      ORD_LT: f.n = 1'b1;
      ORD_EQ: begin f.z = 1'b1; f.c = 1'b1; end
      ORD_GT: f.c = 1'b1;
      default: begin f.c = 1'b1; f.v = 1'b1; end
    endcase
    return f;
  endfunction
endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack #(
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 11,
  parameter int DM = 52,
  localparam int DW = 1 + DE + DM,
  localparam int SW = 1 + SE + SM,
  localparam int KW = DE + DM
) (
  input  logic [DW-1:0] raw,
  input  logic          dbl_sel,
  output logic          sign,
  output logic          is_nan,
  output logic          is_zero,
  output logic [KW-1:0] key
);
  logic [SE-1:0] s_exp;
  logic [SM-1:0] s_man;
  logic [DE-1:0] d_exp;
  logic [DM-1:0] d_man;

  assign s_exp = raw[SE+SM-1:SM];
  assign s_man = raw[SM-1:0];
  assign d_exp = raw[DE+DM-1:DM];
  assign d_man = raw[DM-1:0];

  always_comb begin
    if (dbl_sel) begin
      sign    = raw[DW-1];
      is_nan  = (&d_exp) && (|d_man);
      is_zero = ~|{d_exp, d_man};
      key     = {d_exp, d_man};
    end else begin
      sign    = raw[SW-1];
      is_nan  = (&s_exp) && (|s_man);
      is_zero = ~|{s_exp, s_man};
      key     = KW'({s_exp, s_man});
    end
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int KW = 63
) (
  input  logic          a_sign,
  input  logic          a_nan,
  input  logic          a_zero,
  input  logic [KW-1:0] a_key,
  input  logic          b_sign,
  input  logic          b_nan,
  input  logic          b_zero,
  input  logic [KW-1:0] b_key,
  output order_e        order
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt = a_key < b_key;
  assign mag_eq = a_key == b_key;

  always_comb begin
    if (a_nan || b_nan) begin
      order = ORD_UN;
    end else if (a_zero && b_zero) begin
      order = ORD_EQ;
    end else if (a_sign != b_sign) begin
      order = a_sign ? ORD_LT : ORD_GT;
    end else if (mag_eq) begin
      order = ORD_EQ;
    end else if (a_sign) begin
      order = mag_lt ? ORD_GT : ORD_LT;
    end else begin
      order = mag_lt ? ORD_LT : ORD_GT;
    end
  end
endmodule

// File: rtl/fcmp_flagreg.sv
module fcmp_flagreg
  import fcmp_pkg::*;
#(
  parameter int STAT_W = 32,
  localparam int FTOP = STAT_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  nzcv_t             din,
  input  logic              xfer,
  output nzcv_t             fp_flags,
  output logic [3:0]        core_flags,
  output logic [STAT_W-1:0] status_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_flags   <= '0;
      core_flags <= '0;
    end else begin
      if (load) fp_flags <= din;
      if (xfer) core_flags <= fp_flags;
    end
  end

  assign status_word = {fp_flags, {FTOP{1'b0}}};

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(fp_flags));

  a_r10_core_copy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> core_flags == $past(fp_flags));

  a_r4_n_c_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fp_flags.n && fp_flags.c));
endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
  import fcmp_pkg::*;
#(
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 11,
  parameter int DM = 52,
  parameter int STAT_W = 32,
  localparam int DW = 1 + DE + DM,
  localparam int KW = DE + DM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic              dbl_sel,
  input  logic              cmp_zero,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic              xfer_core,
  output logic [STAT_W-1:0] status_word,
  output logic [3:0]        core_flags
);
  logic [DW-1:0] opnd [2];
  logic          sgn  [2];
  logic          nan  [2];
  logic          zer  [2];
  logic [KW-1:0] key  [2];
  order_e        order;
  nzcv_t         fp_flags;
  logic          fire;

  assign cmp_ready = 1'b1;
  assign fire      = cmp_valid && cmp_ready;
  assign opnd[0]   = op_a;
  assign opnd[1]   = cmp_zero ? '0 : op_b;

  for (genvar i = 0; i < 2; i++) begin : g_unpack
    fcmp_unpack #(.SE(SE), .SM(SM), .DE(DE), .DM(DM)) u_unpack (
      .raw     (opnd[i]),
      .dbl_sel (dbl_sel),
      .sign    (sgn[i]),
      .is_nan  (nan[i]),
      .is_zero (zer[i]),
      .key     (key[i])
    );
  end

  fcmp_order #(.KW(KW)) u_order (
    .a_sign (sgn[0]), .a_nan (nan[0]), .a_zero (zer[0]), .a_key (key[0]),
    .b_sign (sgn[1]), .b_nan (nan[1]), .b_zero (zer[1]), .b_key (key[1]),
    .order  (order)
  );

  fcmp_flagreg #(.STAT_W(STAT_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fire),
    .din         (flags_of(order)),
    .xfer        (xfer_core),
    .fp_flags    (fp_flags),
    .core_flags  (core_flags),
    .status_word (status_word)
  );

  a_r2_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (nan[0] || nan[1])) |=> status_word[STAT_W-1 -: 4] == 4'b0011);

  a_r3_same_bits_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !nan[0] && opnd[0] == opnd[1]) |=> status_word[STAT_W-1 -: 4] == 4'b0110);

  a_r5_signed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && zer[0] && zer[1]) |=> status_word[STAT_W-1 -: 4] == 4'b0110);
endmodule

// File: tb/sim_fcmp_nzcv.sv
module sim_fcmp_nzcv;
  localparam int SE = 3, SM = 2, DE = 3, DM = 3;
  localparam int DW = 1 + DE + DM;
  localparam int SW = 1 + SE + SM;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic          cmp_ready;
  logic          dbl_sel = 1'b0;
  logic          cmp_zero = 1'b0;
  logic [DW-1:0] op_a = '0;
  logic [DW-1:0] op_b = '0;
  logic          xfer_core = 1'b0;
  logic [31:0]   status_word;
  logic [3:0]    core_flags;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fcmp_nzcv #(.SE(SE), .SM(SM), .DE(DE), .DM(DM)) u0 (
    .clk, .rst_n, .cmp_valid, .cmp_ready, .dbl_sel, .cmp_zero,
    .op_a, .op_b, .xfer_core, .status_word, .core_flags
  );

  function automatic real pow2(int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic bit is_nan(int bits, int mw);
    int e = (bits >> mw) & ((1 << SE) - 1);
    int m = bits & ((1 << mw) - 1);
    return (e == (1 << SE) - 1) && (m != 0);
  endfunction

  function automatic real val_of(int bits, int mw);
    int  s = (bits >> (SE + mw)) & 1;
    int  e = (bits >> mw) & ((1 << SE) - 1);
    int  m = bits & ((1 << mw) - 1);
    int  bias = (1 << (SE - 1)) - 1;
    real r;
    if (e == (1 << SE) - 1) r = 1.0e30;
    else if (e == 0) r = real'(m) * pow2(1 - bias - mw);
    else r = real'((1 << mw) + m) * pow2(e - bias - mw);
    return s ? -r : r;
  endfunction

  function automatic logic [3:0] model(int a, int b, bit dbl, bit z);
    int mw = dbl ? DM : SM;
    int bb = z ? 0 : b;
    real va, vb;
    if (is_nan(a, mw) || is_nan(bb, mw)) return 4'b0011;
    va = val_of(a, mw);
    vb = val_of(bb, mw);
    if (va == vb) return 4'b0110;
    if (va < vb) return 4'b1000;
    return 4'b0010;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string tag_of(logic [3:0] f, int a, int b, int mw, bit z);
    int mag = (1 << (SE + mw)) - 1;
    if (z) return "R7";
    if (f == 4'b0011) return "R2";
    if ((a & mag) == (b & mag) && (a & mag) == 0) return "R5";
    if (f == 4'b0110) return "R3";
    return "R4";
  endfunction

  // Called at a falling edge; drives a compare and checks at the next falling edge.
  task automatic do_cmp(int a, int b, bit dbl, bit z, bit junk);
    logic [3:0] exp;
    int mw = dbl ? DM : SM;
    dbl_sel   = dbl;
    cmp_zero  = z;
    cmp_valid = 1'b1;
    op_a = DW'(a);
    op_b = DW'(b);
    if (!dbl) begin
      op_a[DW-1] = junk;   // R6: upper bit ignored in single format
      op_b[DW-1] = ~junk;
    end
    exp = model(a, b, dbl, z);
    @(negedge clk);
    check(dbl ? tag_of(exp, a, b, mw, z) : (junk ? "R6" : tag_of(exp, a, b, mw, z)),
          status_word, {exp, 28'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", status_word, 32'h0);
    check("R1", {28'h0, core_flags}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {28'h0, core_flags}, 32'h0);

    for (int a = 0; a < (1 << SW); a++)
      for (int b = 0; b < (1 << SW); b++)
        do_cmp(a, b, 1'b0, 1'b0, bit'((a ^ b) & 1));

    for (int a = 0; a < (1 << DW); a++)
      for (int b = 0; b < (1 << DW); b++)
        do_cmp(a, b, 1'b1, 1'b0, 1'b0);

    for (int a = 0; a < (1 << DW); a++) begin
      do_cmp(a, (a * 5 + 3) & ((1 << DW) - 1), 1'b1, 1'b1, 1'b0);
      do_cmp(a & ((1 << SW) - 1), (a * 7 + 1) & ((1 << SW) - 1), 1'b0, 1'b1, 1'b0);
    end

    // R8: flags hold while no compare is requested
    do_cmp('h18, 'h20, 1'b1, 1'b0, 1'b0);   // 1.0 < 2.0
    cmp_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      op_a = DW'('h39);
      op_b = DW'(k);
      @(negedge clk);
      check("R8", status_word, 32'h8000_0000);
    end

    // R9: packed status word after an unordered result
    do_cmp('h39, 'h18, 1'b1, 1'b0, 1'b0);
    check("R9", status_word, 32'h3000_0000);
    do_cmp('h18, 'h18, 1'b1, 1'b0, 1'b0);
    check("R9", status_word, 32'h6000_0000);

    // R10: core transfer takes the pre-edge flags
    do_cmp('h18, 'h20, 1'b1, 1'b0, 1'b0);   // flags 1000
    xfer_core = 1'b1;
    do_cmp('h20, 'h18, 1'b1, 1'b0, 1'b0);   // flags 0010, same-edge transfer
    check("R10", {28'h0, core_flags}, 32'h8);
    xfer_core = 1'b0;
    do_cmp('h39, 'h18, 1'b1, 1'b0, 1'b0);   // flags 0011, no transfer
    check("R10", {28'h0, core_flags}, 32'h8);
    cmp_valid = 1'b0;
    xfer_core = 1'b1;
    @(negedge clk);
    xfer_core = 1'b0;
    check("R10", {28'h0, core_flags}, 32'h3);
    @(negedge clk);
    check("R10", {28'h0, core_flags}, 32'h3);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", status_word, 32'h0);
    check("R1", {28'h0, core_flags}, 32'h0);
    check("R1", {31'h0, cmp_ready}, 32'h1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule